// File: doc/BRIEF.md
# Path Status Byte Capture Register

This block keeps the path status octet that the far end returns once in every received frame, and shows it to a management interface. Each arriving octet comes with a one-cycle strobe. Two capture policies are available, chosen by a mode input.

In copy mode the register follows the stream and always holds the latest octet. In latch mode the first non-zero octet is captured and then frozen until management reads the register. The read releases the hold. Because an error-free far end usually sends 02h, a frozen 02h can hide later error reports. A sticky drop flag therefore shows that octets were discarded while the register was frozen.

The register value is also split into its two fields: a 4-bit far-end error count in bits 7:4 and a 3-bit defect code in bits 3:1. Bit 0 is spare.

Top module: `psb_status_reg`

## Requirements
- R1: After reset the register value is 00h, the hold indicator is 0 and the drop flag is 0.
- R2: With `mode_latch` = 0 (copy mode), every strobed octet replaces the register value on the next clock edge, and a zero octet does so too. The hold indicator stays 0.
- R3: With `mode_latch` = 1 (latch mode) and no hold active, a strobed non-zero octet is loaded into the register and the hold indicator goes to 1.
- R4: In latch mode, while the hold is active and no read is presented, strobed octets leave the register value unchanged.
- R5: In latch mode, a strobed 00h octet never changes the register value.
- R6: A read strobe releases the hold on the next edge. The read itself does not change the register value, which is the value returned by the read.
- R7: When a read and a strobed octet fall in the same cycle, the octet is handled as if no hold were active. A non-zero octet in latch mode is therefore captured and the hold set again.
- R8: A change of `mode_latch` releases any active hold.
- R9: The drop flag is set when an octet is strobed in latch mode while the hold is active and no read is presented. It stays set until a read, and a read clears it.
- R10: `rei_count` equals register bits 7:4 and `rdi_code` equals register bits 3:1. For 02h this gives a count of 0 and a code of 001.
- R11: Cycles with no octet strobe leave the register value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_octet | input | 8 | Received status octet |
| rx_valid | input | 1 | One-cycle strobe marking a new octet |
| mode_latch | input | 1 | 0 selects copy mode, 1 selects latch mode |
| rd_strobe | input | 1 | Management read of the register |
| reg_value | output | 8 | Current register value |
| rei_count | output | 4 | Error count field (bits 7:4) |
| rdi_code | output | 3 | Defect code field (bits 3:1) |
| held | output | 1 | Latch-mode hold active |
| drop_flag | output | 1 | Sticky: octets were discarded while held |

## Verification
Two events can meet in one cycle: a management read and the arrival of a new octet. The bench holds the register frozen on one value. It then raises the read strobe in the same cycle as a different non-zero octet, and expects that octet in the register with the hold set again and the drop flag clear. In a second case the colliding octet is zero, and the bench expects the old value to stay with the hold released. A mode flip that coincides with an arrival is judged in the same way, against the released state.

// File: rtl/psb_pkg.sv
package psb_pkg;

    typedef enum logic {
        PSB_MODE_COPY  = 1'b0,
        PSB_MODE_LATCH = 1'b1
    } psb_mode_e;

    // Decision taken for one arriving octet
    typedef enum logic [1:0] {
        PSB_ACT_NONE    = 2'd0,
        PSB_ACT_LOAD    = 2'd1,
        PSB_ACT_CAPTURE = 2'd2,
        PSB_ACT_DROP    = 2'd3
    } psb_action_e;

endpackage

// File: rtl/psb_policy.sv
module psb_policy
    import psb_pkg::*;
#(
    parameter int OCTET_W = 8
) (
    input  logic               valid,
    input  logic [OCTET_W-1:0] octet,
    input  psb_mode_e          mode,
    input  logic               hold_eff,
    output psb_action_e        action
);

    logic octet_nz;

    assign octet_nz = |octet;

    always_comb begin
        action = PSB_ACT_NONE;
        if (valid) begin
            if (mode == PSB_MODE_COPY) begin
                action = PSB_ACT_LOAD;
            end else if (hold_eff) begin
                action = PSB_ACT_DROP;
            end else if (octet_nz) begin
                action = PSB_ACT_CAPTURE;
            end else begin
                action = PSB_ACT_NONE;
            end
        end
    end

endmodule

// File: rtl/psb_field_decode.sv
module psb_field_decode #(
    parameter int OCTET_W = 8,
    parameter int REI_W   = 4,
    parameter int RDI_W   = 3
) (
    input  logic [OCTET_W-1:0] value,
    output logic [REI_W-1:0]   rei,
    output logic [RDI_W-1:0]   rdi
);

    localparam int REI_LSB = OCTET_W - REI_W;
    localparam int RDI_LSB = REI_LSB - RDI_W;

    for (genvar i = 0; i < REI_W; i++) begin : g_rei
        assign rei[i] = value[REI_LSB + i];
    end

    for (genvar j = 0; j < RDI_W; j++) begin : g_rdi
        assign rdi[j] = value[RDI_LSB + j];
    end

endmodule

// File: rtl/psb_capture_core.sv
module psb_capture_core
    import psb_pkg::*;
#(
    parameter int OCTET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [OCTET_W-1:0] octet,
    input  psb_mode_e          mode,
    input  logic               rd,
    output logic [OCTET_W-1:0] value,
    output logic               hold,
    output logic               dropped
);

    typedef struct packed {
        logic [OCTET_W-1:0] value;
        logic               hold;
        logic               dropped;
        psb_mode_e          mode;
    } state_t;

    state_t      st_q, st_d;
    logic        mode_chg;
    logic        release_hold;
    logic        hold_eff;
    psb_action_e action;

    assign mode_chg     = (mode != st_q.mode);
    assign release_hold = rd | mode_chg;
    assign hold_eff     = st_q.hold & ~release_hold;

    psb_policy #(.OCTET_W(OCTET_W)) u_policy (
        .valid    (valid),
        .octet    (octet),
        .mode     (mode),
        .hold_eff (hold_eff),
        .action   (action)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode;
        st_d.hold = hold_eff;
        if (rd) begin
            st_d.dropped = 1'b0;
        end
        case (action)
            PSB_ACT_LOAD: begin
                st_d.value = octet;
                st_d.hold  = 1'b0;
            end
            PSB_ACT_CAPTURE: begin
                st_d.value = octet;
                st_d.hold  = 1'b1;
            end
            PSB_ACT_DROP: begin
                st_d.dropped = 1'b1;
            end
            default: begin
            end
        endcase
        if (mode == PSB_MODE_COPY) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value   <= '0;
            st_q.hold    <= 1'b0;
            st_q.dropped <= 1'b0;
            st_q.mode    <= PSB_MODE_COPY;
        end else begin
            st_q <= st_d;
        end
    end

    assign value   = st_q.value;
    assign hold    = st_q.hold;
    assign dropped = st_q.dropped;

endmodule

// File: rtl/psb_status_reg.sv
module psb_status_reg
    import psb_pkg::*;
#(
    parameter int OCTET_W = 8,
    parameter int REI_W   = 4,
    parameter int RDI_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCTET_W-1:0] rx_octet,
    input  logic               rx_valid,
    input  logic               mode_latch,
    input  logic               rd_strobe,
    output logic [OCTET_W-1:0] reg_value,
    output logic [REI_W-1:0]   rei_count,
    output logic [RDI_W-1:0]   rdi_code,
    output logic               held,
    output logic               drop_flag
);

    psb_mode_e mode_sel;

    assign mode_sel = mode_latch ? PSB_MODE_LATCH : PSB_MODE_COPY;

    psb_capture_core #(.OCTET_W(OCTET_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (rx_valid),
        .octet   (rx_octet),
        .mode    (mode_sel),
        .rd      (rd_strobe),
        .value   (reg_value),
        .hold    (held),
        .dropped (drop_flag)
    );

    psb_field_decode #(
        .OCTET_W (OCTET_W),
        .REI_W   (REI_W),
        .RDI_W   (RDI_W)
    ) u_decode (
        .value (reg_value),
        .rei   (rei_count),
        .rdi   (rdi_code)
    );

endmodule

// File: rtl/psb_status_chk.sv
module psb_status_chk #(
    parameter int OCTET_W = 8,
    parameter int REI_W   = 4,
    parameter int RDI_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OCTET_W-1:0] rx_octet,
    input logic               rx_valid,
    input logic               mode_latch,
    input logic               rd_strobe,
    input logic [OCTET_W-1:0] reg_value,
    input logic [REI_W-1:0]   rei_count,
    input logic [RDI_W-1:0]   rdi_code,
    input logic               held,
    input logic               drop_flag
);

    AST_COPY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_latch && rx_valid) |=> (reg_value == $past(rx_octet) && !held)); // R2

    AST_CAPTURE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_latch && rx_valid && rx_octet != '0 && (!held || rd_strobe))
        |=> (held && reg_value == $past(rx_octet))); // R7

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (held && mode_latch && !rd_strobe) |=> (held && $stable(reg_value))); // R4

    AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_latch && rx_valid && rx_octet == '0) |=> $stable(reg_value)); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(reg_value)); // R11

    AST_READ_CLEARS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !drop_flag); // R9

    AST_DROP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (held && mode_latch && rx_valid && !rd_strobe) |=> drop_flag); // R9

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rx_valid) |=> !held); // R6

    AST_MODE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_latch != $past(mode_latch) && !rx_valid) |-> ##1 !held); // R8

    AST_FIELDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rei_count == reg_value[OCTET_W-1 -: REI_W]) &&
        (rdi_code == reg_value[OCTET_W-REI_W-1 -: RDI_W])); // R10

endmodule

bind psb_status_reg psb_status_chk #(
    .OCTET_W (OCTET_W),
    .REI_W   (REI_W),
    .RDI_W   (RDI_W)
) u_psb_status_chk (.*);

// File: tb/psb_status_reg_test.sv
module psb_status_reg_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_octet;
    logic       rx_valid;
    logic       mode_latch;
    logic       rd_strobe;
    logic [7:0] reg_value;
    logic [3:0] rei_count;
    logic [2:0] rdi_code;
    logic       held;
    logic       drop_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    psb_status_reg uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_octet   (rx_octet),
        .rx_valid   (rx_valid),
        .mode_latch (mode_latch),
        .rd_strobe  (rd_strobe),
        .reg_value  (reg_value),
        .rei_count  (rei_count),
        .rdi_code   (rdi_code),
        .held       (held),
        .drop_flag  (drop_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, returns at next falling edge
    task automatic step(input logic v, input logic [7:0] o, input logic r);
        @(negedge clk);
        rx_valid  = v;
        rx_octet  = o;
        rd_strobe = r;
        @(negedge clk);
        rx_valid  = 1'b0;
        rx_octet  = 8'h00;
        rd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0;
        rx_octet = 8'h00;
        rd_strobe = 1'b0;
        mode_latch = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 value", reg_value, 8'h00);
        check("R1 held", {7'd0, held}, 8'h00);
        check("R1 drop", {7'd0, drop_flag}, 8'h00);
    endtask

    task automatic t_copy();
        mode_latch = 1'b0;
        step(1'b1, 8'h02, 1'b0);
        check("R2 first", reg_value, 8'h02);
        check("R10 rei", {4'd0, rei_count}, 8'h00);
        check("R10 rdi", {5'd0, rdi_code}, 8'h01);
        step(1'b1, 8'hA6, 1'b0);
        check("R2 overwrite", reg_value, 8'hA6);
        check("R10 rei A6", {4'd0, rei_count}, 8'h0A);
        check("R10 rdi A6", {5'd0, rdi_code}, 8'h03);
        step(1'b0, 8'h00, 1'b0);
        check("R11 idle", reg_value, 8'hA6);
        step(1'b1, 8'h00, 1'b0);
        check("R2 zero loads", reg_value, 8'h00);
        check("R2 no hold", {7'd0, held}, 8'h00);
    endtask

    task automatic t_latch();
        do_reset();
        mode_latch = 1'b1;
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h00, 1'b0);
        check("R5 zero", reg_value, 8'h00);
        check("R5 no hold", {7'd0, held}, 8'h00);
        step(1'b1, 8'h02, 1'b0);
        check("R3 capture", reg_value, 8'h02);
        check("R3 held", {7'd0, held}, 8'h01);
        check("R9 drop clear", {7'd0, drop_flag}, 8'h00);
        step(1'b1, 8'h3A, 1'b0);
        check("R4 ignored", reg_value, 8'h02);
        check("R9 drop set", {7'd0, drop_flag}, 8'h01);
        step(1'b1, 8'h00, 1'b0);
        check("R4 zero ignored", reg_value, 8'h02);
        step(1'b0, 8'h00, 1'b1);
        check("R6 value kept", reg_value, 8'h02);
        check("R6 released", {7'd0, held}, 8'h00);
        check("R9 read clears", {7'd0, drop_flag}, 8'h00);
        step(1'b1, 8'h00, 1'b0);
        check("R5 zero after read", reg_value, 8'h02);
        step(1'b1, 8'h54, 1'b0);
        check("R3 recapture", reg_value, 8'h54);
    endtask

    task automatic t_collide();
        do_reset();
        mode_latch = 1'b1;
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h02, 1'b0);
        step(1'b1, 8'h10, 1'b0);
        check("R9 pre", {7'd0, drop_flag}, 8'h01);
        step(1'b1, 8'hF4, 1'b1);
        check("R7 new captured", reg_value, 8'hF4);
        check("R7 held again", {7'd0, held}, 8'h01);
        check("R9 cleared on collide", {7'd0, drop_flag}, 8'h00);
        step(1'b1, 8'h00, 1'b1);
        check("R7 zero collide", reg_value, 8'hF4);
        check("R7 released", {7'd0, held}, 8'h00);
    endtask

    task automatic t_mode();
        do_reset();
        mode_latch = 1'b1;
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h0C, 1'b0);
        check("R8 pre held", {7'd0, held}, 8'h01);
        mode_latch = 1'b0;
        step(1'b0, 8'h00, 1'b0);
        check("R8 released", {7'd0, held}, 8'h00);
        check("R8 value", reg_value, 8'h0C);
        mode_latch = 1'b1;
        step(1'b1, 8'h66, 1'b0);
        check("R8 capture after", reg_value, 8'h66);
        mode_latch = 1'b0;
        step(1'b1, 8'h12, 1'b0);
        check("R8 flip with octet", reg_value, 8'h12);
        check("R8 flip no hold", {7'd0, held}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_copy();
        t_latch();
        t_collide();
        t_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule